// File: doc/BRIEF.md
# Exclusive Access Monitor

This block tracks one exclusive reservation for a single requester that runs load-exclusive / store-exclusive semaphore sequences. A load-exclusive request returns the addressed data and records the address and access size as the reservation. A later store-exclusive is allowed only if that reservation is still intact and matches the store exactly. An allowed store drives a write to memory and reports status 0. A refused store writes nothing and reports status 1. Either way the reservation is gone afterwards.

Three other events also drop the reservation: a clear command on the request port, an invalidate input signalling that some other agent wrote to the reserved words, and reset. Accesses come in four sizes: byte, halfword, word and doubleword. The byte and halfword forms carry only the low 8 or 16 bits of the register value. The doubleword form spans two consecutive words, the base and base+4, as one unit. Coherence across several cores is not handled here.

The memory read data for the request address is presented alongside the request. All responses and memory writes come out of registers one cycle after the request is sampled.

Top module: `excl_monitor`

## Requirements
- R1: After reset, and after any reset applied while a reservation is held, no reservation exists. resp_valid, mem_we and mem_be are 0, and the first store-exclusive fails.
- R2: A load-exclusive (req_op 0) gives resp_valid=1 and resp_status=0 one cycle later. resp_data is zero-extended: byte (size 0) is taken from byte lane addr[1:0] of word 0; halfword (size 1) is taken from half addr[1]; word (size 2) is word 0; doubleword (size 3) places base in bits 31:0 and base+4 in bits 63:32.
- R3: A store-exclusive (req_op 1) whose address and size equal the reservation succeeds one cycle later. The outputs are resp_status=0, resp_data=0, and mem_addr equal to the request address with bits 1:0 cleared. For byte and halfword stores, mem_wdata holds the low 8 or 16 data bits replicated across word 0, with byte enable 1<<addr[1:0] or 4'b0011<<(2*addr[1]). A word store writes data bits 31:0 with enables 0x0F.
- R4: A store-exclusive with no reservation, or with a different address or size, reports resp_status=1 and resp_data=1, and leaves mem_we, mem_be, mem_addr and mem_wdata at 0.
- R5: Every store-exclusive, successful or not, drops the reservation, so a repeated store fails.
- R6: A clear command (req_op 2) drops the reservation and gives no response and no write.
- R7: A new load-exclusive replaces the reservation, so a store to the earlier address fails.
- R8: An invalidate (inval_valid) whose word address (bits AW-1:2) equals a reserved word drops the reservation. For a doubleword reservation this covers either word. An invalidate to any other word leaves the reservation intact.
- R9: An invalidate that hits in the same cycle as a matching store-exclusive makes that store fail. An invalidate in the same cycle as a load-exclusive does not remove the new reservation.
- R10: A successful doubleword store sets mem_we=2'b11 and mem_be=0xFF, with base data in bits 31:0 and base+4 data in bits 63:32.
- R11: Op code 3 is ignored: no response, no write, and the reservation is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 2 | 0 load-exclusive, 1 store-exclusive, 2 clear, 3 reserved |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 doubleword |
| req_addr | input | AW | Byte address of the request |
| req_wdata | input | 64 | Store data (bits 63:32 used only by doubleword) |
| mem_rd_data | input | 64 | Memory words at the aligned request address and +4 |
| inval_valid | input | 1 | External write seen |
| inval_addr | input | AW | Byte address of that external write |
| resp_valid | output | 1 | Response for a load or store-exclusive |
| resp_status | output | 1 | 0 success, 1 failure |
| resp_data | output | 64 | Load data, or status word for a store |
| mem_we | output | 2 | Write enable per word lane (base, base+4) |
| mem_addr | output | AW | Word-aligned write address |
| mem_be | output | 8 | Byte enables, lane 0 in bits 3:0 |
| mem_wdata | output | 64 | Write data, lane 0 in bits 31:0 |

## Verification
The critical coincidence is an external invalidate and a store-exclusive to the same reservation arriving in the same clock. The stimulus table places both in one vector. The store must come back with status 1 and with write enables and byte enables at zero. The same pairing is applied to a load-exclusive. A store issued in the next vector must then succeed, which shows that the fresh reservation outlived the concurrent invalidate.

// File: rtl/excl_mon_pkg.sv
package excl_mon_pkg;

    localparam int WORD_W  = 32;
    localparam int LANES   = 2;
    localparam int BUS_W   = WORD_W * LANES;
    localparam int BE_W    = BUS_W / 8;

    typedef enum logic [1:0] {
        OP_LOAD  = 2'd0,
        OP_STORE = 2'd1,
        OP_CLEAR = 2'd2,
        OP_RSVD  = 2'd3
    } excl_op_e;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_HALF  = 2'd1,
        SZ_WORD  = 2'd2,
        SZ_DWORD = 2'd3
    } excl_size_e;

endpackage

// File: rtl/excl_tag_unit.sv
module excl_tag_unit
    import excl_mon_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_req,
    input  logic          drop_req,
    input  logic [AW-1:0] req_addr,
    input  logic [1:0]    req_size,
    input  logic          inval_valid,
    input  logic [AW-1:0] inval_addr,
    output logic          permit
);
    localparam int WAW = AW - 2;

    typedef struct packed {
        logic          valid;
        logic [AW-1:0] addr;
        logic [1:0]    size;
    } tag_t;

    tag_t           tag_d, tag_q;
    logic [WAW-1:0] tag_word;
    logic [WAW-1:0] inv_word;
    logic           inval_hit;
    logic           exact_match;

    always_comb begin
        tag_word    = tag_q.addr[AW-1:2];
        inv_word    = inval_addr[AW-1:2];
        inval_hit   = inval_valid && tag_q.valid &&
                      ((inv_word == tag_word) ||
                       ((tag_q.size == SZ_DWORD) && (inv_word == tag_word + WAW'(1))));
        exact_match = tag_q.valid && (tag_q.addr == req_addr) && (tag_q.size == req_size);
        permit      = exact_match && !inval_hit;

        tag_d = tag_q;
        if (inval_hit || drop_req) begin
            tag_d.valid = 1'b0;
        end
        if (load_req) begin
            tag_d.valid = 1'b1;
            tag_d.addr  = req_addr;
            tag_d.size  = req_size;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tag_q <= '0;
        end else begin
            tag_q <= tag_d;
        end
    end

endmodule

// File: rtl/excl_wr_fmt.sv
module excl_wr_fmt
    import excl_mon_pkg::*;
(
    input  logic [1:0]       size,
    input  logic [1:0]       addr_lo,
    input  logic [BUS_W-1:0] wdata,
    output logic [BUS_W-1:0] lane_data,
    output logic [BE_W-1:0]  lane_be,
    output logic [LANES-1:0] lane_we
);
    always_comb begin
        lane_data = '0;
        lane_be   = '0;
        lane_we   = 2'b01;
        unique case (excl_size_e'(size))
            SZ_BYTE: begin
                lane_data[WORD_W-1:0] = {4{wdata[7:0]}};
                lane_be[3:0]          = 4'b0001 << addr_lo;
            end
            SZ_HALF: begin
                lane_data[WORD_W-1:0] = {2{wdata[15:0]}};
                lane_be[3:0]          = addr_lo[1] ? 4'b1100 : 4'b0011;
            end
            SZ_WORD: begin
                lane_data[WORD_W-1:0] = wdata[WORD_W-1:0];
                lane_be[3:0]          = 4'b1111;
            end
            default: begin
                lane_data = wdata;
                lane_be   = '1;
                lane_we   = 2'b11;
            end
        endcase
    end

endmodule

// File: rtl/excl_rd_fmt.sv
module excl_rd_fmt
    import excl_mon_pkg::*;
(
    input  logic [1:0]       size,
    input  logic [1:0]       addr_lo,
    input  logic [BUS_W-1:0] rd_data,
    output logic [BUS_W-1:0] ld_data
);
    always_comb begin
        ld_data = '0;
        unique case (excl_size_e'(size))
            SZ_BYTE:  ld_data[7:0]        = rd_data[{addr_lo, 3'b000} +: 8];
            SZ_HALF:  ld_data[15:0]       = rd_data[{addr_lo[1], 4'b0000} +: 16];
            SZ_WORD:  ld_data[WORD_W-1:0] = rd_data[WORD_W-1:0];
            default:  ld_data             = rd_data;
        endcase
    end

endmodule

// File: rtl/excl_monitor.sv
module excl_monitor
    import excl_mon_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [1:0]    req_op,
    input  logic [1:0]    req_size,
    input  logic [AW-1:0] req_addr,
    input  logic [63:0]   req_wdata,
    input  logic [63:0]   mem_rd_data,
    input  logic          inval_valid,
    input  logic [AW-1:0] inval_addr,
    output logic          resp_valid,
    output logic          resp_status,
    output logic [63:0]   resp_data,
    output logic [1:0]    mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [7:0]    mem_be,
    output logic [63:0]   mem_wdata
);
    typedef struct packed {
        logic             resp_valid;
        logic             resp_status;
        logic [BUS_W-1:0] resp_data;
        logic [LANES-1:0] mem_we;
        logic [AW-1:0]    mem_addr;
        logic [BE_W-1:0]  mem_be;
        logic [BUS_W-1:0] mem_wdata;
    } out_t;

    out_t             out_d, out_q;
    excl_op_e         op;
    logic             is_load, is_store, is_clear;
    logic             permit;
    logic [BUS_W-1:0] ld_data;
    logic [BUS_W-1:0] lane_data;
    logic [BE_W-1:0]  lane_be;
    logic [LANES-1:0] lane_we;

    always_comb begin
        op       = excl_op_e'(req_op);
        is_load  = req_valid && (op == OP_LOAD);
        is_store = req_valid && (op == OP_STORE);
        is_clear = req_valid && (op == OP_CLEAR);
    end

    excl_tag_unit #(.AW(AW)) u_tag (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_req    (is_load),
        .drop_req    (is_store || is_clear),
        .req_addr    (req_addr),
        .req_size    (req_size),
        .inval_valid (inval_valid),
        .inval_addr  (inval_addr),
        .permit      (permit)
    );

    excl_rd_fmt u_rd (
        .size    (req_size),
        .addr_lo (req_addr[1:0]),
        .rd_data (mem_rd_data),
        .ld_data (ld_data)
    );

    excl_wr_fmt u_wr (
        .size      (req_size),
        .addr_lo   (req_addr[1:0]),
        .wdata     (req_wdata),
        .lane_data (lane_data),
        .lane_be   (lane_be),
        .lane_we   (lane_we)
    );

    always_comb begin
        out_d = '0;
        if (is_load) begin
            out_d.resp_valid = 1'b1;
            out_d.resp_data  = ld_data;
        end
        if (is_store) begin
            out_d.resp_valid   = 1'b1;
            out_d.resp_status  = !permit;
            out_d.resp_data[0] = !permit;
            if (permit) begin
                out_d.mem_we    = lane_we;
                out_d.mem_addr  = {req_addr[AW-1:2], 2'b00};
                out_d.mem_be    = lane_be;
                out_d.mem_wdata = lane_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign resp_valid  = out_q.resp_valid;
    assign resp_status = out_q.resp_status;
    assign resp_data   = out_q.resp_data;
    assign mem_we      = out_q.mem_we;
    assign mem_addr    = out_q.mem_addr;
    assign mem_be      = out_q.mem_be;
    assign mem_wdata   = out_q.mem_wdata;

endmodule

// File: rtl/excl_monitor_chk.sv
module excl_monitor_chk
    import excl_mon_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic [1:0] req_op,
    input logic       resp_valid,
    input logic       resp_status,
    input logic [1:0] mem_we,
    input logic [7:0] mem_be
);
    // R2
    resp_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (req_op == OP_LOAD || req_op == OP_STORE)) |=> resp_valid);

    // R11
    quiet_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && (req_op == OP_LOAD || req_op == OP_STORE)) |=> (!resp_valid && mem_we == 2'b00));

    // R4
    fail_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_status) |-> (mem_we == 2'b00 && mem_be == 8'h00));

    // R3
    write_needs_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we != 2'b00) |-> (resp_valid && !resp_status && mem_be != 8'h00));

    // R10
    dword_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we[1] |-> (mem_we[0] && mem_be == 8'hFF));

endmodule

bind excl_monitor excl_monitor_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_op      (req_op),
    .resp_valid  (resp_valid),
    .resp_status (resp_status),
    .mem_we      (mem_we),
    .mem_be      (mem_be)
);

// File: tb/excl_monitor_tb_top.sv
`timescale 1ns/1ps
module excl_monitor_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_op = 2'd0;
    logic [1:0]  req_size = 2'd0;
    logic [31:0] req_addr = 32'd0;
    logic [63:0] req_wdata = 64'd0;
    logic [63:0] mem_rd_data;
    logic        inval_valid = 1'b0;
    logic [31:0] inval_addr = 32'd0;
    logic        resp_valid, resp_status;
    logic [63:0] resp_data;
    logic [1:0]  mem_we;
    logic [31:0] mem_addr;
    logic [7:0]  mem_be;
    logic [63:0] mem_wdata;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        return {a[15:0] ^ 16'h5A5A, a[15:0]};
    endfunction

    assign mem_rd_data = {mem_word({req_addr[31:2], 2'b00} + 32'd4), mem_word({req_addr[31:2], 2'b00})};

    excl_monitor #(.AW(32)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
        .mem_rd_data(mem_rd_data), .inval_valid(inval_valid), .inval_addr(inval_addr),
        .resp_valid(resp_valid), .resp_status(resp_status), .resp_data(resp_data),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata)
    );

    typedef struct packed {
        logic        vld;
        logic [1:0]  op;
        logic [1:0]  sz;
        logic [31:0] addr;
        logic        inv;
        logic [31:0] ia;
        logic        erv;
        logic        est;
        logic [1:0]  ewe;
        logic [7:0]  ebe;
        logic [7:0]  req;
    } vec_t;

    function automatic vec_t mk(logic vld, logic [1:0] op, logic [1:0] sz, logic [31:0] addr,
                                logic inv, logic [31:0] ia, logic erv, logic est,
                                logic [1:0] ewe, logic [7:0] ebe, logic [7:0] req);
        return '{vld, op, sz, addr, inv, ia, erv, est, ewe, ebe, req};
    endfunction

    localparam logic [63:0] WD = 64'hA1B2C3D4_11223344;
    localparam int NV = 33;
    localparam vec_t VEC [NV] = '{
        mk(1, 1, 2, 32'h100, 0, 0, 1, 1, 2'b00, 8'h00, 4),   // R4 no reservation
        mk(1, 0, 2, 32'h100, 0, 0, 1, 0, 2'b00, 8'h00, 2),   // R2 word load
        mk(1, 1, 2, 32'h100, 0, 0, 1, 0, 2'b01, 8'h0F, 3),   // R3 word store
        mk(1, 1, 2, 32'h100, 0, 0, 1, 1, 2'b00, 8'h00, 5),   // R5 repeat fails
        mk(1, 0, 1, 32'h202, 0, 0, 1, 0, 2'b00, 8'h00, 2),   // R2 half load
        mk(1, 1, 1, 32'h202, 0, 0, 1, 0, 2'b01, 8'h0C, 3),   // R3 half store
        mk(1, 0, 0, 32'h303, 0, 0, 1, 0, 2'b00, 8'h00, 2),   // R2 byte load
        mk(1, 1, 0, 32'h302, 0, 0, 1, 1, 2'b00, 8'h00, 4),   // R4 address mismatch
        mk(1, 0, 0, 32'h301, 0, 0, 1, 0, 2'b00, 8'h00, 2),   // R2
        mk(1, 1, 0, 32'h301, 0, 0, 1, 0, 2'b01, 8'h02, 3),   // R3 byte store
        mk(1, 0, 2, 32'h400, 0, 0, 1, 0, 2'b00, 8'h00, 2),
        mk(1, 2, 2, 32'h400, 0, 0, 0, 0, 2'b00, 8'h00, 6),   // R6 clear
        mk(1, 1, 2, 32'h400, 0, 0, 1, 1, 2'b00, 8'h00, 6),   // R6 store fails
        mk(1, 0, 2, 32'h500, 0, 0, 1, 0, 2'b00, 8'h00, 2),
        mk(1, 0, 2, 32'h600, 0, 0, 1, 0, 2'b00, 8'h00, 7),   // R7 replaces
        mk(1, 1, 2, 32'h500, 0, 0, 1, 1, 2'b00, 8'h00, 7),   // R7 old address fails
        mk(1, 0, 3, 32'h700, 0, 0, 1, 0, 2'b00, 8'h00, 2),
        mk(1, 1, 2, 32'h700, 0, 0, 1, 1, 2'b00, 8'h00, 4),   // R4 size mismatch
        mk(1, 0, 3, 32'h700, 0, 0, 1, 0, 2'b00, 8'h00, 10),  // R10 dword load
        mk(1, 1, 3, 32'h700, 0, 0, 1, 0, 2'b11, 8'hFF, 10),  // R10 dword store
        mk(1, 0, 2, 32'h800, 0, 0, 1, 0, 2'b00, 8'h00, 2),
        mk(0, 0, 0, 32'h0,   1, 32'h804, 0, 0, 2'b00, 8'h00, 8), // R8 miss
        mk(1, 1, 2, 32'h800, 0, 0, 1, 0, 2'b01, 8'h0F, 8),   // R8 tag survived
        mk(1, 0, 3, 32'h900, 0, 0, 1, 0, 2'b00, 8'h00, 2),
        mk(0, 0, 0, 32'h0,   1, 32'h906, 0, 0, 2'b00, 8'h00, 8), // R8 upper word hit
        mk(1, 1, 3, 32'h900, 0, 0, 1, 1, 2'b00, 8'h00, 8),   // R8 store fails
        mk(1, 0, 2, 32'hA00, 0, 0, 1, 0, 2'b00, 8'h00, 2),
        mk(1, 1, 2, 32'hA00, 1, 32'hA00, 1, 1, 2'b00, 8'h00, 9), // R9 same-cycle kill
        mk(1, 0, 2, 32'hB00, 1, 32'hB00, 1, 0, 2'b00, 8'h00, 9), // R9 load wins
        mk(1, 1, 2, 32'hB00, 0, 0, 1, 0, 2'b01, 8'h0F, 9),   // R9 store succeeds
        mk(1, 0, 2, 32'hC00, 0, 0, 1, 0, 2'b00, 8'h00, 2),
        mk(1, 3, 2, 32'hC00, 0, 0, 0, 0, 2'b00, 8'h00, 11),  // R11 reserved op
        mk(1, 1, 2, 32'hC00, 0, 0, 1, 0, 2'b01, 8'h0F, 11)   // R11 tag untouched
    };

    task automatic chk(input bit ok, input string what, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", what, act, exp);
        end
    endtask

    function automatic logic [63:0] exp_load(logic [1:0] sz, logic [31:0] a);
        logic [31:0] w0 = mem_word({a[31:2], 2'b00});
        logic [31:0] w1 = mem_word({a[31:2], 2'b00} + 32'd4);
        case (sz)
            2'd0: return {56'd0, w0[8*a[1:0] +: 8]};
            2'd1: return {48'd0, w0[16*a[1] +: 16]};
            2'd2: return {32'd0, w0};
            default: return {w1, w0};
        endcase
    endfunction

    function automatic logic [63:0] exp_wdata(logic [1:0] sz);
        case (sz)
            2'd0: return {32'd0, {4{WD[7:0]}}};
            2'd1: return {32'd0, {2{WD[15:0]}}};
            2'd2: return {32'd0, WD[31:0]};
            default: return WD;
        endcase
    endfunction

    task automatic drive(input vec_t v);
        req_valid   = v.vld;
        req_op      = v.op;
        req_size    = v.sz;
        req_addr    = v.addr;
        req_wdata   = WD;
        inval_valid = v.inv;
        inval_addr  = v.ia;
    endtask

    task automatic idle();
        req_valid = 1'b0; req_op = 2'd0; inval_valid = 1'b0;
    endtask

    initial begin
        #(5.0 * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(resp_valid == 0 && mem_we == 0 && mem_be == 0, "R1 reset outputs",
            {resp_valid, mem_we, mem_be}, 128'd0);

        for (int i = 0; i < NV; i++) begin
            logic [63:0] ed;
            logic [63:0] ew;
            logic [31:0] ea;
            drive(VEC[i]);
            @(negedge clk);
            ed = !VEC[i].erv ? 64'd0 : (VEC[i].op == 2'd0) ? exp_load(VEC[i].sz, VEC[i].addr) : {63'd0, VEC[i].est};
            ew = (VEC[i].ewe != 0) ? exp_wdata(VEC[i].sz) : 64'd0;
            ea = (VEC[i].ewe != 0) ? {VEC[i].addr[31:2], 2'b00} : 32'd0;
            chk(resp_valid == VEC[i].erv && resp_status == VEC[i].est && resp_data == ed,
                $sformatf("R%0d vec %0d response", VEC[i].req, i),
                {resp_valid, resp_status, resp_data}, {VEC[i].erv, VEC[i].est, ed});
            chk(mem_we == VEC[i].ewe && mem_be == VEC[i].ebe && mem_addr == ea && mem_wdata == ew,
                $sformatf("R%0d vec %0d write", VEC[i].req, i),
                {mem_we, mem_be, mem_addr, mem_wdata}, {VEC[i].ewe, VEC[i].ebe, ea, ew});
        end
        idle();
        @(negedge clk);
        chk(resp_valid == 0 && mem_we == 0, "R11 idle quiet", {resp_valid, mem_we}, 128'd0);

        // R1 reset while a reservation is held
        drive(mk(1, 0, 2, 32'hE00, 0, 0, 1, 0, 0, 0, 1));
        @(negedge clk);
        idle();
        rst_n = 1'b0;
        @(negedge clk);
        chk(resp_valid == 0 && mem_we == 0, "R1 reset clears outputs", {resp_valid, mem_we}, 128'd0);
        rst_n = 1'b1;
        drive(mk(1, 1, 2, 32'hE00, 0, 0, 1, 1, 0, 0, 1));
        @(negedge clk);
        idle();
        chk(resp_valid == 1 && resp_status == 1 && mem_we == 0, "R1 store after reset fails",
            {resp_valid, resp_status, mem_we}, {1'b1, 1'b1, 2'b00});
        @(negedge clk);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule